// File: doc/BRIEF.md
# Interrupt and Exception Acceptance Unit

This block sits beside an instruction execution core and, at each instruction boundary, decides which pending event is serviced and produces its 8-bit vector. Three event classes compete: exceptions raised by the core or by the block itself, a non-maskable request, and a maskable request whose vector an external interrupt controller supplies. Only one event is serviced per boundary, and the highest-ranked class wins. A losing exception is discarded. A losing interrupt stays pending and competes again at a later boundary.

The block owns the interrupt-enable flag and the non-maskable blocking latch. Commands that set or clear the enable flag are honoured only when the current privilege level is numerically no greater than the I/O privilege level. Any other such command leaves the flag as it was and queues a protection exception. For exceptions that carry an error code, the block assembles that code from an index and two marker bits. Descriptor lookup and stack handling take place downstream.

The result is a registered one-cycle pulse that appears in the cycle after the boundary. It has no ready input: the consumer has to take the vector in that cycle, so the output cannot apply back-pressure. The maskable request is a level that the controller holds until the block pulses the acknowledge.

Top module: `irq_accept_unit`

## Requirements
- R1: After reset the enable flag is 0, no non-maskable event is blocked or pending, and the valid, error-valid and acknowledge outputs are 0.
- R2: A pending exception outranks the non-maskable and maskable requests. Its 5-bit vector comes out zero-extended to 8 bits. Interrupts that lose to it remain pending and are serviced at later boundaries.
- R3: The non-maskable request outranks the maskable one, is serviced with vector 2, and sets the blocking latch.
- R4: A non-maskable request pulse that arrives while the latch is set is ignored. The return strobe clears the latch. A request in the same cycle as the return strobe is accepted.
- R5: The maskable request is serviced only while the enable flag is 1. It uses the externally supplied vector, and the acknowledge pulses in the same cycle as the valid output.
- R6: A set or clear command with CPL ≤ IOPL updates the flag one cycle later. A boundary in the same cycle as the command arbitrates with the old flag value. Clear wins if both commands are given together.
- R7: A set or clear command with CPL > IOPL leaves the flag unchanged and causes a protection exception, vector 13 with error code 0, at the next boundary.
- R8: The error code is 16 bits: bit 0 is EXT (external cause), bit 1 is the interrupt-table marker, bit 2 is 0, and bits 15:3 hold the 13-bit index. Error-valid is 1 only for exceptions that carry a code.
- R9: A queued protection exception outranks a core exception at the same boundary. The losing core exception is discarded and does not appear at any later boundary.
- R10: The valid output pulses for exactly one cycle, and only in the cycle after a boundary that had at least one eligible event.

Ports table follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boundary_i | input | 1 | Instruction boundary strobe |
| exc_req_i | input | 1 | Core exception present at this boundary |
| exc_vec_i | input | 5 | Core exception vector (0–31) |
| exc_has_err_i | input | 1 | Core exception carries an error code |
| exc_ext_i | input | 1 | Error code EXT marker |
| exc_idt_i | input | 1 | Error code interrupt-table marker |
| exc_idx_i | input | 13 | Error code index |
| nmi_req_i | input | 1 | Non-maskable request pulse |
| mi_req_i | input | 1 | Maskable request level |
| mi_vec_i | input | 8 | Maskable vector from the controller (32–255) |
| iret_i | input | 1 | Interrupt return strobe |
| sti_i | input | 1 | Set-enable-flag command |
| cli_i | input | 1 | Clear-enable-flag command |
| cpl_i | input | 2 | Current privilege level |
| iopl_i | input | 2 | I/O privilege level |
| ev_valid_o | output | 1 | Serviced-event pulse |
| ev_vec_o | output | 8 | Serviced vector |
| ev_err_valid_o | output | 1 | Error code is valid |
| ev_err_code_o | output | 16 | Error code |
| mi_ack_o | output | 1 | Acknowledge to the interrupt controller |
| if_flag_o | output | 1 | Interrupt-enable flag |
| nmi_blocked_o | output | 1 | Non-maskable blocking latch |

## Verification
Two pairs of functions can fall in the same cycle here. In the first pair, a clear command arrives on the same edge as a boundary with a maskable request waiting. The bench expects the maskable event to be serviced on the old flag, and expects the flag to read 0 afterwards. In the second pair, the return strobe and a fresh non-maskable pulse are driven together while the latch is set. The bench expects that request to be taken, so vector 2 appears at the next boundary and the latch is set again. A scoreboard compares each emitted event with its queued expectation and reports any pulse that no expectation accounts for.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;
  localparam int VEC_W     = 8;
  localparam int EXC_VEC_W = 5;
  localparam int IDX_W     = 13;
  localparam int ERR_W     = IDX_W + 3;
  localparam int PL_W      = 2;
  localparam logic [VEC_W-1:0] NMI_VEC = 8'd2;
  localparam logic [VEC_W-1:0] GP_VEC  = 8'd13;

  typedef enum logic [2:0] {
    EV_NONE = 3'd0,
    EV_GP   = 3'd1,
    EV_EXC  = 3'd2,
    EV_NMI  = 3'd3,
    EV_MI   = 3'd4
  } ev_class_e;
endpackage

// File: rtl/ie_flag_ctrl.sv
module ie_flag_ctrl
  import irq_accept_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sti,
  input  logic            cli,
  input  logic [PL_W-1:0] cpl,
  input  logic [PL_W-1:0] iopl,
  output logic            if_q,
  output logic            gp_raise
);
  logic cmd, allowed;

  assign cmd      = sti | cli;
  assign allowed  = (cpl <= iopl);
  assign gp_raise = cmd & ~allowed;

  always_ff @(posedge clk) begin
    if (!rst_n)              if_q <= 1'b0;
    else if (cmd && allowed) if_q <= ~cli;
  end

  // A refused command must not move the flag.
  assert_flag_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    gp_raise |=> $stable(if_q));
endmodule

// File: rtl/nmi_block_latch.sv
module nmi_block_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_req,
  input  logic nmi_take,
  input  logic iret,
  output logic nmi_pend_q,
  output logic nmi_blocked_q
);
  logic blocked_eff;

  assign blocked_eff = nmi_blocked_q & ~iret;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_pend_q    <= 1'b0;
      nmi_blocked_q <= 1'b0;
    end else begin
      if (nmi_take)                     nmi_pend_q <= 1'b0;
      else if (nmi_req && !blocked_eff) nmi_pend_q <= 1'b1;
      if (nmi_take)  nmi_blocked_q <= 1'b1;
      else if (iret) nmi_blocked_q <= 1'b0;
    end
  end

  assert_take_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_take |=> nmi_blocked_q);
  assert_blocked_ignores_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_blocked_q && !iret && !nmi_pend_q) |=> !nmi_pend_q);
endmodule

// File: rtl/event_arbiter.sv
module event_arbiter
  import irq_accept_pkg::*;
(
  input  logic                 boundary,
  input  logic                 gp_pend,
  input  logic                 exc_req,
  input  logic [EXC_VEC_W-1:0] exc_vec,
  input  logic                 exc_has_err,
  input  logic                 exc_ext,
  input  logic                 exc_idt,
  input  logic [IDX_W-1:0]     exc_idx,
  input  logic                 nmi_pend,
  input  logic                 mi_req,
  input  logic [VEC_W-1:0]     mi_vec,
  input  logic                 if_q,
  output ev_class_e            sel,
  output logic [VEC_W-1:0]     vec,
  output logic                 err_valid,
  output logic [ERR_W-1:0]     err_code
);
  always_comb begin
    sel       = EV_NONE;
    vec       = '0;
    err_valid = 1'b0;
    err_code  = '0;
    if (boundary) begin
      if (gp_pend) begin
        sel       = EV_GP;
        vec       = GP_VEC;
        err_valid = 1'b1;
      end else if (exc_req) begin
        sel       = EV_EXC;
        vec       = {{(VEC_W-EXC_VEC_W){1'b0}}, exc_vec};
        err_valid = exc_has_err;
        if (exc_has_err) err_code = {exc_idx, 1'b0, exc_idt, exc_ext};
      end else if (nmi_pend) begin
        sel = EV_NMI;
        vec = NMI_VEC;
      end else if (mi_req && if_q) begin
        sel = EV_MI;
        vec = mi_vec;
      end
    end
  end
endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit
  import irq_accept_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        boundary_i,
  input  logic        exc_req_i,
  input  logic [4:0]  exc_vec_i,
  input  logic        exc_has_err_i,
  input  logic        exc_ext_i,
  input  logic        exc_idt_i,
  input  logic [12:0] exc_idx_i,
  input  logic        nmi_req_i,
  input  logic        mi_req_i,
  input  logic [7:0]  mi_vec_i,
  input  logic        iret_i,
  input  logic        sti_i,
  input  logic        cli_i,
  input  logic [1:0]  cpl_i,
  input  logic [1:0]  iopl_i,
  output logic        ev_valid_o,
  output logic [7:0]  ev_vec_o,
  output logic        ev_err_valid_o,
  output logic [15:0] ev_err_code_o,
  output logic        mi_ack_o,
  output logic        if_flag_o,
  output logic        nmi_blocked_o
);
  logic             if_q, gp_raise, gp_pend_q;
  logic             nmi_pend_q, nmi_blocked_q;
  ev_class_e        sel;
  logic [VEC_W-1:0] vec;
  logic             err_valid;
  logic [ERR_W-1:0] err_code;

  ie_flag_ctrl u_flag (
    .clk(clk), .rst_n(rst_n), .sti(sti_i), .cli(cli_i),
    .cpl(cpl_i), .iopl(iopl_i), .if_q(if_q), .gp_raise(gp_raise)
  );

  nmi_block_latch u_nmi (
    .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req_i),
    .nmi_take(sel == EV_NMI), .iret(iret_i),
    .nmi_pend_q(nmi_pend_q), .nmi_blocked_q(nmi_blocked_q)
  );

  event_arbiter u_arb (
    .boundary(boundary_i), .gp_pend(gp_pend_q), .exc_req(exc_req_i),
    .exc_vec(exc_vec_i), .exc_has_err(exc_has_err_i), .exc_ext(exc_ext_i),
    .exc_idt(exc_idt_i), .exc_idx(exc_idx_i), .nmi_pend(nmi_pend_q),
    .mi_req(mi_req_i), .mi_vec(mi_vec_i), .if_q(if_q),
    .sel(sel), .vec(vec), .err_valid(err_valid), .err_code(err_code)
  );

  // Queued protection exception; a fresh refusal outranks consumption.
  always_ff @(posedge clk) begin
    if (!rst_n)             gp_pend_q <= 1'b0;
    else if (gp_raise)      gp_pend_q <= 1'b1;
    else if (sel == EV_GP)  gp_pend_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_valid_o     <= 1'b0;
      ev_vec_o       <= '0;
      ev_err_valid_o <= 1'b0;
      ev_err_code_o  <= '0;
      mi_ack_o       <= 1'b0;
    end else begin
      ev_valid_o     <= (sel != EV_NONE);
      ev_vec_o       <= vec;
      ev_err_valid_o <= err_valid;
      ev_err_code_o  <= err_code;
      mi_ack_o       <= (sel == EV_MI);
    end
  end

  assign if_flag_o     = if_q;
  assign nmi_blocked_o = nmi_blocked_q;

  assert_valid_after_boundary_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid_o |-> $past(boundary_i));
  assert_ack_needs_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mi_ack_o |-> (ev_valid_o && $past(if_flag_o)));
  assert_err_only_low_vec_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_err_valid_o |-> (ev_valid_o && ev_vec_o < 8'd32));
  assert_gp_served_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (gp_pend_q && boundary_i && !gp_raise) |=> (!gp_pend_q && ev_valid_o && ev_vec_o == GP_VEC));
endmodule

// File: tb/irq_accept_unit_tb_top.sv
module irq_accept_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic boundary_i = 0, exc_req_i = 0, exc_has_err_i = 0, exc_ext_i = 0, exc_idt_i = 0;
  logic [4:0]  exc_vec_i = '0;
  logic [12:0] exc_idx_i = '0;
  logic nmi_req_i = 0, mi_req_i = 0, iret_i = 0, sti_i = 0, cli_i = 0;
  logic [7:0] mi_vec_i = '0;
  logic [1:0] cpl_i = '0, iopl_i = '0;
  logic ev_valid_o, ev_err_valid_o, mi_ack_o, if_flag_o, nmi_blocked_o;
  logic [7:0]  ev_vec_o;
  logic [15:0] ev_err_code_o;

  int errors = 0, checks = 0;
  bit done = 0;

  typedef struct {
    logic [7:0]  vec;
    logic        errv;
    logic [15:0] code;
    logic        ack;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  irq_accept_unit dut_i (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic push(logic [7:0] v, logic ev, logic [15:0] c, logic a, string t);
    exp_t e;
    e.vec = v; e.errv = ev; e.code = c; e.ack = a; e.tag = t;
    sb.push_back(e);
  endtask

  // One boundary cycle, then the result cycle.
  task automatic bnd();
    boundary_i = 1;
    cyc();
    boundary_i = 0;
    exc_req_i = 0; exc_has_err_i = 0;
  endtask

  task automatic nmi_pulse();
    nmi_req_i = 1;
    cyc();
    nmi_req_i = 0;
  endtask

  // Monitor: every valid pulse must match the head of the scoreboard.
  always @(negedge clk) begin
    if (rst_n && !done && ev_valid_o) begin
      if (sb.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10 unexpected event actual=%0h expected=none", ev_vec_o);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk({e.tag, " vec"}, ev_vec_o, e.vec);
        chk({e.tag, " errv"}, ev_err_valid_o, e.errv);
        if (e.errv) chk({e.tag, " code"}, ev_err_code_o, e.code);
        chk({e.tag, " ack"}, mi_ack_o, e.ack);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) cyc();
    // R1 reset state
    chk("R1 if", if_flag_o, 0);
    chk("R1 blocked", nmi_blocked_o, 0);
    chk("R1 valid", ev_valid_o, 0);
    chk("R1 ack", mi_ack_o, 0);
    rst_n = 1;
    cyc();

    // R5 maskable refused while flag 0
    mi_req_i = 1; mi_vec_i = 8'h40;
    bnd();
    chk("R5 masked", ev_valid_o, 0);

    // R6 privileged set
    sti_i = 1; cpl_i = 0; iopl_i = 0;
    cyc(); sti_i = 0;
    chk("R6 set", if_flag_o, 1);

    // R5 accepted
    push(8'h40, 0, 0, 1, "R5 mi");
    bnd();
    cyc();
    chk("R10 one cycle pulse", ev_valid_o, 0);

    // R2 exception beats pending NMI and maskable; R8 error code
    nmi_pulse();
    exc_req_i = 1; exc_vec_i = 5'd14; exc_has_err_i = 1; exc_ext_i = 1; exc_idt_i = 0; exc_idx_i = 13'd5;
    push(8'd14, 1, 16'h0029, 0, "R2 R8 exc");
    bnd();
    push(8'd2, 0, 0, 0, "R3 nmi after exc");
    bnd();
    chk("R3 blocked", nmi_blocked_o, 1);
    push(8'h40, 0, 0, 1, "R2 mi still pending");
    bnd();
    mi_req_i = 0;

    // R8 idt marker and full index
    exc_req_i = 1; exc_vec_i = 5'd11; exc_has_err_i = 1; exc_ext_i = 0; exc_idt_i = 1; exc_idx_i = 13'h1FFF;
    push(8'd11, 1, 16'hFFFA, 0, "R8 idt");
    bnd();
    // R8 exception without code
    exc_req_i = 1; exc_vec_i = 5'd0; exc_has_err_i = 0;
    push(8'd0, 0, 0, 0, "R8 no code");
    bnd();

    // R4 blocked NMI ignored, then return clears the latch
    nmi_pulse();
    iret_i = 1; cyc(); iret_i = 0;
    chk("R4 cleared", nmi_blocked_o, 0);
    bnd();
    chk("R4 ignored", ev_valid_o, 0);

    // R4 request together with return strobe is taken
    nmi_pulse();
    push(8'd2, 0, 0, 0, "R3 nmi");
    bnd();
    iret_i = 1; nmi_req_i = 1; cyc(); iret_i = 0; nmi_req_i = 0;
    push(8'd2, 0, 0, 0, "R4 iret+nmi");
    bnd();
    chk("R4 reblocked", nmi_blocked_o, 1);

    // R7 refused clear
    cpl_i = 3; iopl_i = 0; cli_i = 1;
    cyc(); cli_i = 0;
    chk("R7 flag kept", if_flag_o, 1);
    push(8'd13, 1, 16'h0000, 0, "R7 gp");
    bnd();

    // R9 queued protection exception beats core exception, which is lost
    sti_i = 1; cyc(); sti_i = 0;
    exc_req_i = 1; exc_vec_i = 5'd6; exc_has_err_i = 0;
    push(8'd13, 1, 16'h0000, 0, "R9 gp wins");
    bnd();
    bnd();
    chk("R9 dropped", ev_valid_o, 0);

    // R6 clear coincident with boundary uses old flag
    cpl_i = 0; mi_req_i = 1; mi_vec_i = 8'hA5; cli_i = 1;
    push(8'hA5, 0, 0, 1, "R6 old flag");
    bnd();
    cli_i = 0;
    chk("R6 cleared", if_flag_o, 0);
    bnd();
    chk("R6 now masked", ev_valid_o, 0);

    // R6 both commands: clear wins
    sti_i = 1; cli_i = 1; cyc(); sti_i = 0; cli_i = 0;
    chk("R6 both", if_flag_o, 0);

    // R10 no pulse without boundary
    sti_i = 1; cyc(); sti_i = 0;
    repeat (4) begin
      cyc();
      chk("R10 no boundary", ev_valid_o, 0);
    end
    mi_req_i = 0;
    cyc();
    chk("R10 scoreboard drained", sb.size(), 0);
    finish_run();
  end
endmodule